// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Framing Recovery

This block turns an asynchronous serial line into characters. It is clocked by its own receive clock, which runs at sixteen times the bit rate and has no tie to any transmit clock. While idle it waits for the line to go low. It confirms a start bit by sampling again at mid-bit. It then takes five to eight data bits, least significant bit first, each sampled at its centre. Last, it checks a single stop bit.

Each finished character goes into a one-entry holding register and is offered on a valid/ready output. Two status flags travel with it. The framing flag marks a character whose stop bit was sampled low; the bits received are still delivered. The overrun flag marks a character that replaced an earlier one the consumer had not yet taken.

After a bad stop bit the receiver waits an extra half bit before it starts looking for a start bit again. Because of that wait, a stop level that stays low past its nominal end is not read as the start of a new character.

Top module: `rxa_receiver`

## Requirements
- R1: While reset is asserted and right after it, `rx_valid_o`, `rx_frame_err_o` and `rx_overrun_o` are 0.
- R2: A low line is accepted as a start bit only if it is still low 8 ticks after it was first seen. A low pulse that has returned high by then produces no character.
- R3: `rx_len_i` selects the character length: 0 = 5, 1 = 6, 2 = 7, 3 = 8 data bits. Bits arrive LSB first, one every 16 ticks. Bit k is placed at `rx_data_o[k]`, and unused upper bits read 0. The length is captured when the start bit is confirmed.
- R4: A character whose stop bit is sampled high is delivered with `rx_frame_err_o` = 0.
- R5: A character whose stop bit is sampled low is still delivered, with the bits received and `rx_frame_err_o` = 1.
- R6: After a framing error, the start-bit search resumes 8 ticks after the stop sample. A stop level held low for up to 6 ticks past the nominal end of the stop bit yields no extra character.
- R7: While `rx_valid_o` = 1 and `rx_ready_i` = 0, the valid signal and the data hold steady until a new character arrives. A cycle with both valid and ready high consumes the character.
- R8: If a character completes while the held one is valid and not being consumed, it overwrites the held one and is delivered with `rx_overrun_o` = 1.
- R9: A character that completes while the holding register is empty is delivered with `rx_overrun_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx16 | input | 1 | Receive clock at 16x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rxd_i | input | 1 | Serial data line, idle high |
| rx_len_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| rx_ready_i | input | 1 | Consumer accepts the held character |
| rx_valid_o | output | 1 | A character is held |
| rx_data_o | output | 8 | Held character, right aligned |
| rx_frame_err_o | output | 1 | Stop bit of held character was low |
| rx_overrun_o | output | 1 | Held character replaced an unread one |

## Verification
The embedded properties check on every cycle the handshake and flag rules of the holding register. These are that an unconsumed character stays put, that an overwrite raises the overrun flag, and that a load into an empty register clears it. They also check the framer's own sequencing: data is entered only from a confirmed start, the bit index stays within the captured length, and a low stop sample leads into recovery. Only the bench's waveforms can show the rest. This covers correct bit alignment at each length, rejection of a short low pulse, and the absence of a spurious character when a bad stop level runs past its slot. It also covers the end-to-end order of characters and flags as the consumer sees them.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_RECOV = 3'd4
  } rx_state_e;
endpackage

// File: rtl/rxa_sync.sv
module rxa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  // idle level of the line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxa_deframe.sv
module rxa_deframe
  import rxa_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s_i,
  input  logic [1:0]        len_code_i,
  output logic              load_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = OVS / 2;
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(DATA_W - 4);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [DATA_W-1:0] shf_q, shf_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    last_d  = last_q;
    shf_d   = shf_q;
    load_o  = 1'b0;
    ferr_o  = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        cnt_d = '0;
        if (!rx_s_i) state_d = ST_START;
      end
      ST_START: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_MID) begin
          cnt_d = '0;
          if (rx_s_i) begin
            state_d = ST_HUNT;
          end else begin
            state_d = ST_DATA;
            idx_d   = '0;
            shf_d   = '0;
            last_d  = IDX_BASE + IDX_W'(len_code_i);
          end
        end
      end
      ST_DATA: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_FULL) begin
          cnt_d        = '0;
          shf_d[idx_q] = rx_s_i;
          if (idx_q == last_q) state_d = ST_STOP;
          else                 idx_d   = idx_q + 1'b1;
        end
      end
      ST_STOP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_FULL) begin
          cnt_d   = '0;
          load_o  = 1'b1;
          ferr_o  = !rx_s_i;
          state_d = rx_s_i ? ST_HUNT : ST_RECOV;
        end
      end
      ST_RECOV: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_MID) begin
          cnt_d   = '0;
          state_d = ST_HUNT;
        end
      end
      default: begin
        state_d = ST_HUNT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      shf_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      shf_q   <= shf_d;
    end
  end

  assign data_o = shf_q;

  // R2
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(rx_s_i));

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q <= last_q));

  // R6
  recov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && ferr_o) |=> (state_q == ST_RECOV));

  // R6
  recov_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && $past(state_q) == ST_RECOV) |-> ($past(cnt_q) == CNT_MID));
endmodule

// File: rtl/rxa_hold.sv
module rxa_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              ld_ferr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ferr_q, ferr_d;
  logic              ovr_q, ovr_d;
  logic              busy;

  always_comb begin
    busy    = valid_q && !ready_i;
    valid_d = valid_q;
    data_d  = data_q;
    ferr_d  = ferr_q;
    ovr_d   = ovr_q;
    if (load_i) begin
      valid_d = 1'b1;
      data_d  = ld_data_i;
      ferr_d  = ld_ferr_i;
      ovr_d   = busy;
    end else if (valid_q && ready_i) begin
      valid_d = 1'b0;
      ferr_d  = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign ferr_o  = ferr_q;
  assign ovr_o   = ovr_q;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i && !load_i) |=> (valid_q && $stable(data_q)));

  // R7
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready_i && !load_i) |=> !valid_q);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && valid_q && !ready_i) |=> ovr_q);

  // R9
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !valid_q) |=> !ovr_q);
endmodule

// File: rtl/rxa_receiver.sv
module rxa_receiver #(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_rx16,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic [1:0]        rx_len_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_frame_err_o,
  output logic              rx_overrun_o
);
  logic              rx_s;
  logic              ld;
  logic              ld_ferr;
  logic [DATA_W-1:0] ld_data;

  rxa_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk_rx16),
    .rst_n (rst_n),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  rxa_deframe #(.OVS(OVS), .DATA_W(DATA_W)) u_deframe (
    .clk        (clk_rx16),
    .rst_n      (rst_n),
    .rx_s_i     (rx_s),
    .len_code_i (rx_len_i),
    .load_o     (ld),
    .ferr_o     (ld_ferr),
    .data_o     (ld_data)
  );

  rxa_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk_rx16),
    .rst_n     (rst_n),
    .load_i    (ld),
    .ld_data_i (ld_data),
    .ld_ferr_i (ld_ferr),
    .ready_i   (rx_ready_i),
    .valid_o   (rx_valid_o),
    .data_o    (rx_data_o),
    .ferr_o    (rx_frame_err_o),
    .ovr_o     (rx_overrun_o)
  );
endmodule

// File: tb/tb_rxa_receiver.sv
`timescale 1ns/1ps
module tb_rxa_receiver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd;
  logic [1:0] len;
  logic       rdy;
  logic       valid;
  logic [7:0] data;
  logic       ferr;
  logic       ovr;

  typedef struct {
    logic [7:0] d;
    logic       fe;
    logic       ov;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  rxa_receiver dut (
    .clk_rx16       (clk),
    .rst_n          (rst_n),
    .rxd_i          (rxd),
    .rx_len_i       (len),
    .rx_ready_i     (rdy),
    .rx_valid_o     (valid),
    .rx_data_o      (data),
    .rx_frame_err_o (ferr),
    .rx_overrun_o   (ovr)
  );

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input logic stop, input int stop_ticks);
    rxd = 1'b0;
    tick(16);
    for (int i = 0; i < nbits; i++) begin
      rxd = d[i];
      tick(16);
    end
    rxd = stop;
    tick(stop_ticks);
    rxd = 1'b1;
  endtask

  task automatic expect_char(input logic [7:0] d, input logic fe, input logic ov, input string req);
    exp_t e;
    e.d = d; e.fe = fe; e.ov = ov; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: transfer happens on the next edge when valid and ready are both high
  always @(negedge clk) begin
    if (rst_n === 1'b1 && valid && rdy) begin
      if (sb_q.size() == 0) begin
        check("R2/R6 unexpected char", 1'b0, {22'd0, ferr, ovr, data}, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, (data == e.d) && (ferr == e.fe) && (ovr == e.ov),
              {22'd0, ferr, ovr, data}, {22'd0, e.fe, e.ov, e.d});
      end
    end
  end

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check("watchdog", 1'b0, 32'(cyc), 32'd0);
      report();
    end
  end

  initial begin
    logic [7:0] pats [2];
    pats[0] = 8'hA5;
    pats[1] = 8'h3C;
    rst_n = 1'b0;
    rxd   = 1'b1;
    len   = 2'd3;
    rdy   = 1'b1;
    tick(5);
    // R1 reset state
    check("R1 valid", valid == 1'b0, 32'(valid), 32'd0);
    check("R1 flags", {ferr, ovr} == 2'b00, 32'({ferr, ovr}), 32'd0);
    rst_n = 1'b1;
    tick(20);
    check("R1 after release", {valid, ferr, ovr} == 3'b000, 32'({valid, ferr, ovr}), 32'd0);

    // R3 every length, two patterns each, R4 and R9 good stop on empty register
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] m;
        m = 8'hFF >> (3 - c);
        len = 2'(c);
        expect_char(pats[p] & m, 1'b0, 1'b0, "R3/R4/R9 length");
        send(pats[p], 5 + c, 1'b1, 16);
        tick(24);
      end
    end

    // R5 low stop bit, then R4 a clean character
    len = 2'd3;
    expect_char(8'h96, 1'b1, 1'b0, "R5 framing error");
    send(8'h96, 8, 1'b0, 16);
    tick(32);
    expect_char(8'h81, 1'b0, 1'b0, "R4 after framing");
    send(8'h81, 8, 1'b1, 16);
    tick(32);

    // R6 stop level held low 6 ticks past its slot: no extra char
    expect_char(8'h66, 1'b1, 1'b0, "R6 framing error");
    send(8'h66, 8, 1'b0, 22);
    tick(48);
    expect_char(8'h99, 1'b0, 1'b0, "R6 next char");
    send(8'h99, 8, 1'b1, 16);
    tick(32);

    // R2 short low pulse rejected
    rxd = 1'b0;
    tick(5);
    rxd = 1'b1;
    tick(48);
    check("R2 no char from glitch", valid == 1'b0, 32'(valid), 32'd0);
    expect_char(8'h42, 1'b0, 1'b0, "R2 char after glitch");
    send(8'h42, 8, 1'b1, 16);
    tick(32);

    // R7 hold while not ready, R8 overrun on overwrite
    rdy = 1'b0;
    send(8'h11, 8, 1'b1, 16);
    tick(24);
    check("R7 held valid", valid == 1'b1, 32'(valid), 32'd1);
    check("R7 held data", data == 8'h11, 32'(data), 32'h11);
    tick(40);
    check("R7 still held", (valid == 1'b1) && (data == 8'h11), 32'(data), 32'h11);
    expect_char(8'h22, 1'b0, 1'b1, "R8 overrun");
    send(8'h22, 8, 1'b1, 16);
    tick(24);
    rdy = 1'b1;
    tick(4);
    check("R7 consumed", valid == 1'b0, 32'(valid), 32'd0);

    // R9 flag clear again on next char
    expect_char(8'h33, 1'b0, 1'b0, "R9 after overrun");
    send(8'h33, 8, 1'b1, 16);
    tick(48);

    check("R3 all expected chars seen", sb_q.size() == 0, 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    report();
  end
endmodule